// File: doc/BRIEF.md
# Four-Instruction Integer Core with Commit Trace

This block is a single-cycle integer core that runs a four-instruction subset of the 32-bit RISC-V base set: register add, add-immediate, word load and word store. One unified word array holds both code and data. The array is written on the clock edge and read combinationally. Code sits from address 0 upward, and preloaded data sits from byte address 0x100 upward. A 32-entry register file backs the datapath, and register 0 always reads as zero.

Every cycle in which the core runs, it executes one instruction and publishes a commit record on its trace outputs. The record holds the PC, the raw word, whether a register was written, its index, the written value, and a flag for undecodable words. A checker can compare that stream against an instruction-level model. A loading port fills the array while the core is held in reset, and it can also be used between instructions. While that port is active the core does not advance.

Top module: `rv_mini_core`

## Requirements
- R1: While `rst_n` is low, `cm_valid` is 0. The first instruction committed after reset is the one at PC 0x00000000.
- R2: Each committed instruction advances the PC by 4, whether it is legal or illegal.
- R3: Opcode bits[6:0]=0010011 with funct3 bits[14:12]=000 is add-immediate. It writes rs1 (bits[19:15]) plus the sign-extended bits[31:20] to rd (bits[11:7]).
- R4: Opcode 0110011 with funct3=000 and funct7 bits[31:25]=0000000 is add. It writes rs1 plus rs2 (bits[24:20]) to rd.
- R5: Opcode 0000011 with funct3=010 is a word load. The address is rs1 plus the sign-extended bits[31:20]. The word is taken from array index address bits[8:2], so the low two address bits are ignored.
- R6: Opcode 0100011 with funct3=010 is a word store. It writes rs2 at rs1 plus the sign-extended {bits[31:25], bits[11:7]}, which a later load returns. A store reports no register write on the trace.
- R7: Register 0 reads as zero. An instruction whose destination is register 0 reports `cm_wen`=0, `cm_wreg`=0 and `cm_wdata`=0.
- R8: Any other word sets `cm_illegal`, writes no register and no memory, and execution continues at PC+4.
- R9: In a committed cycle, `cm_pc` is the current PC and `cm_inst` is the array word at PC bits[8:2].
- R10: While `ld_en` is high, `ld_word` is written at index `ld_idx`, `cm_valid` is 0 and the PC holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Loading-port write strobe; stalls execution |
| ld_idx | input | 7 | Word index for the loading port |
| ld_word | input | 32 | Word written by the loading port |
| cm_valid | output | 1 | An instruction commits this cycle |
| cm_pc | output | 32 | PC of the committing instruction |
| cm_inst | output | 32 | Raw instruction word |
| cm_wen | output | 1 | A register is written |
| cm_wreg | output | 5 | Destination register index (0 when none) |
| cm_wdata | output | 32 | Written value (0 when none) |
| cm_illegal | output | 1 | Word did not decode |

## Verification
A corrupted PC shows up in the very next commit record, either as a wrong `cm_pc` or as a mismatched `cm_inst`. A wrong register value stays hidden until some later instruction reads that register. It then appears on `cm_wdata` of that consumer, or on the value a later load returns after a store. To keep that delay short, the random programs read from a small register pool and store into a data area that following loads read back. Decode errors surface in the same cycle as a wrong `cm_illegal` or write-enable bit.

// File: rtl/rvm_pkg.sv
package rvm_pkg;

    localparam int XLEN = 32;

    localparam logic [6:0] OPC_REG   = 7'b0110011;
    localparam logic [6:0] OPC_IMM   = 7'b0010011;
    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;

    localparam logic [2:0] F3_ADD  = 3'b000;
    localparam logic [2:0] F3_WORD = 3'b010;

    typedef enum logic [2:0] {
        K_ADD,
        K_ADDI,
        K_LW,
        K_SW,
        K_BAD
    } kind_e;

    typedef struct packed {
        kind_e           kind;
        logic [4:0]      rd;
        logic [4:0]      rs1;
        logic [4:0]      rs2;
        logic [XLEN-1:0] imm;
    } dec_t;

endpackage

// File: rtl/rvm_decode.sv
module rvm_decode
    import rvm_pkg::*;
(
    input  logic [XLEN-1:0] inst,
    output dec_t            dec
);

    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;

    always_comb begin
        opc = inst[6:0];
        f3  = inst[14:12];
        f7  = inst[31:25];

        dec.rd   = inst[11:7];
        dec.rs1  = inst[19:15];
        dec.rs2  = inst[24:20];
        dec.imm  = {{(XLEN-12){inst[31]}}, inst[31:20]};
        dec.kind = K_BAD;

        case (opc)
            OPC_REG: begin
                if (f3 == F3_ADD && f7 == 7'd0) dec.kind = K_ADD;
            end
            OPC_IMM: begin
                if (f3 == F3_ADD) dec.kind = K_ADDI;
            end
            OPC_LOAD: begin
                if (f3 == F3_WORD) dec.kind = K_LW;
            end
            OPC_STORE: begin
                if (f3 == F3_WORD) begin
                    dec.kind = K_SW;
                    dec.imm  = {{(XLEN-12){inst[31]}}, inst[31:25], inst[11:7]};
                end
            end
            default: dec.kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/rvm_regfile.sv
module rvm_regfile #(
    parameter int NREGS = 32,
    parameter int W     = 32,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] regs_q [NREGS];

    always_ff @(posedge clk) begin
        if (we && waddr != '0) regs_q[waddr] <= wdata;
    end

    always_comb begin
        rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
        rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];
    end

endmodule

// File: rtl/rvm_mem.sv
module rvm_mem #(
    parameter int WORDS = 128,
    parameter int W     = 32,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] fidx,
    output logic [W-1:0]  fword,
    input  logic [IW-1:0] didx,
    output logic [W-1:0]  dword
);

    logic [W-1:0] arr_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) arr_q[widx] <= wdata;
    end

    always_comb begin
        fword = arr_q[fidx];
        dword = arr_q[didx];
    end

endmodule

// File: rtl/rv_mini_core.sv
module rv_mini_core
    import rvm_pkg::*;
#(
    parameter int MEM_WORDS = 128,
    parameter int NREGS     = 32,
    localparam int IDX_W    = $clog2(MEM_WORDS),
    localparam int RA_W     = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [XLEN-1:0]  ld_word,
    output logic             cm_valid,
    output logic [XLEN-1:0]  cm_pc,
    output logic [XLEN-1:0]  cm_inst,
    output logic             cm_wen,
    output logic [4:0]       cm_wreg,
    output logic [XLEN-1:0]  cm_wdata,
    output logic             cm_illegal
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [XLEN-1:0]  inst_w;
    dec_t             dec;
    logic [XLEN-1:0]  rs1_v, rs2_v;
    logic [XLEN-1:0]  opnd_b, sum_v;
    logic [XLEN-1:0]  load_v;
    logic [IDX_W-1:0] fetch_idx, data_idx;
    logic             run;
    logic             rf_we;
    logic [XLEN-1:0]  rf_wdata;
    logic             mem_we;
    logic [IDX_W-1:0] mem_widx;
    logic [XLEN-1:0]  mem_wdata;

    rvm_mem #(.WORDS(MEM_WORDS), .W(XLEN)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .widx  (mem_widx),
        .wdata (mem_wdata),
        .fidx  (fetch_idx),
        .fword (inst_w),
        .didx  (data_idx),
        .dword (load_v)
    );

    rvm_decode u_dec (
        .inst (inst_w),
        .dec  (dec)
    );

    rvm_regfile #(.NREGS(NREGS), .W(XLEN)) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (dec.rd[RA_W-1:0]),
        .wdata   (rf_wdata),
        .raddr_a (dec.rs1[RA_W-1:0]),
        .raddr_b (dec.rs2[RA_W-1:0]),
        .rdata_a (rs1_v),
        .rdata_b (rs2_v)
    );

    always_comb begin
        run       = rst_n && !ld_en;
        fetch_idx = st_q.pc[IDX_W+1:2];

        // one adder serves register add, immediate add and address generation
        opnd_b   = (dec.kind == K_ADD) ? rs2_v : dec.imm;
        sum_v    = rs1_v + opnd_b;
        data_idx = sum_v[IDX_W+1:2];

        rf_we    = run && (dec.kind == K_ADD || dec.kind == K_ADDI || dec.kind == K_LW)
                   && dec.rd != 5'd0;
        rf_wdata = (dec.kind == K_LW) ? load_v : sum_v;

        // the loading port wins the single write port
        if (ld_en) begin
            mem_we    = 1'b1;
            mem_widx  = ld_idx;
            mem_wdata = ld_word;
        end else begin
            mem_we    = run && dec.kind == K_SW;
            mem_widx  = data_idx;
            mem_wdata = rs2_v;
        end

        st_d    = st_q;
        if (run) st_d.pc = st_q.pc + XLEN'(4);

        cm_valid   = run;
        cm_pc      = st_q.pc;
        cm_inst    = inst_w;
        cm_wen     = rf_we;
        cm_wreg    = rf_we ? dec.rd : 5'd0;
        cm_wdata   = rf_we ? rf_wdata : '0;
        cm_illegal = run && dec.kind == K_BAD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/rvm_core_chk.sv
module rvm_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ld_en,
    input logic        cm_valid,
    input logic [31:0] cm_pc,
    input logic [31:0] cm_inst,
    input logic        cm_wen,
    input logic [4:0]  cm_wreg,
    input logic        cm_illegal
);

    assert_reset_pc_R1: assert property (@(posedge clk)
        !rst_n |=> cm_pc == 32'd0);

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |=> cm_pc == $past(cm_pc) + 32'd4);

    assert_store_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && cm_inst[6:0] == 7'b0100011 && cm_inst[14:12] == 3'b010) |-> !cm_wen);

    assert_x0_never_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cm_wen |-> cm_wreg != 5'd0);

    assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cm_illegal |-> (cm_valid && !cm_wen));

    assert_load_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |-> !cm_valid);

    assert_load_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> $stable(cm_pc));

endmodule

bind rv_mini_core rvm_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_en      (ld_en),
    .cm_valid   (cm_valid),
    .cm_pc      (cm_pc),
    .cm_inst    (cm_inst),
    .cm_wen     (cm_wen),
    .cm_wreg    (cm_wreg),
    .cm_illegal (cm_illegal)
);

// File: tb/rv_mini_core_bench.sv
module rv_mini_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] B_REG = 7'b0110011, B_IMM = 7'b0010011,
                           B_LD = 7'b0000011, B_ST = 7'b0100011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [6:0]  ld_idx = '0;
    logic [31:0] ld_word = '0;
    logic        cm_valid, cm_wen, cm_illegal;
    logic [31:0] cm_pc, cm_inst, cm_wdata;
    logic [4:0]  cm_wreg;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] m_reg [32];
    logic [31:0] m_mem [128];
    logic [31:0] m_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    rv_mini_core u_rv_mini_core (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_word(ld_word),
        .cm_valid(cm_valid), .cm_pc(cm_pc), .cm_inst(cm_inst), .cm_wen(cm_wen),
        .cm_wreg(cm_wreg), .cm_wdata(cm_wdata), .cm_illegal(cm_illegal)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                          input logic [2:0] f3, input logic [4:0] rd,
                                          input logic [6:0] op);
        return {imm, rs1, f3, rd, op};
    endfunction

    function automatic logic [31:0] enc_add(input logic [4:0] rs2, input logic [4:0] rs1,
                                            input logic [4:0] rd);
        return {7'd0, rs2, rs1, 3'b000, rd, B_REG};
    endfunction

    function automatic logic [31:0] enc_sw(input logic [11:0] imm, input logic [4:0] rs2,
                                           input logic [4:0] rs1);
        return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], B_ST};
    endfunction

    function automatic logic [31:0] rv(input logic [4:0] i);
        return (i == 5'd0) ? 32'd0 : m_reg[i];
    endfunction

    // writes m_mem through the loading port while reset is held, then releases reset
    task automatic load_image();
        rst_n = 1'b0;
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_idx = 7'(i); ld_word = m_mem[i];
            if (i == 5) begin
                #1 chk("R1", "valid in reset", {31'd0, cm_valid}, 32'd0);
            end
        end
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_pc  = 32'd0;
        #1 chk("R1", "first pc", cm_pc, 32'd0);
    endtask

    // checks one commit record against the model, then lets it commit
    task automatic step();
        logic [31:0] w, a, ewd;
        logic [6:0]  op;
        logic [2:0]  f3;
        logic [4:0]  rd;
        logic        ewen, eill, do_st;
        string       tag;
        w = m_mem[m_pc[8:2]];
        op = w[6:0]; f3 = w[14:12]; rd = w[11:7];
        ewen = 1'b0; eill = 1'b0; do_st = 1'b0; ewd = 32'd0; tag = "R8"; a = 32'd0;
        if (op == B_REG && f3 == 3'b000 && w[31:25] == 7'd0) begin
            tag = "R4"; ewen = 1'b1; ewd = rv(w[19:15]) + rv(w[24:20]);
        end else if (op == B_IMM && f3 == 3'b000) begin
            tag = "R3"; ewen = 1'b1; ewd = rv(w[19:15]) + {{20{w[31]}}, w[31:20]};
        end else if (op == B_LD && f3 == 3'b010) begin
            tag = "R5"; ewen = 1'b1;
            a = rv(w[19:15]) + {{20{w[31]}}, w[31:20]};
            ewd = m_mem[a[8:2]];
        end else if (op == B_ST && f3 == 3'b010) begin
            tag = "R6"; do_st = 1'b1;
            a = rv(w[19:15]) + {{20{w[31]}}, w[31:25], w[11:7]};
        end else begin
            eill = 1'b1;
        end
        if (ewen && rd == 5'd0) begin
            ewen = 1'b0; tag = "R7";
        end
        if (!ewen) ewd = 32'd0;
        #1;
        chk("R9", "valid", {31'd0, cm_valid}, 32'd1);
        chk("R2", "pc", cm_pc, m_pc);
        chk("R9", "inst", cm_inst, w);
        chk(tag, "wen/wreg/illegal", {25'd0, cm_wen, cm_wreg, cm_illegal},
            {25'd0, ewen, (ewen ? rd : 5'd0), eill});
        chk(tag, "wdata", cm_wdata, ewd);
        if (ewen) m_reg[rd] = ewd;
        if (do_st) m_mem[a[8:2]] = rv(w[24:20]);
        m_pc = m_pc + 32'd4;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] rand_inst();
        int unsigned k, off;
        logic [4:0] rd, ra, rb;
        logic [11:0] imm;
        k  = $urandom_range(0, 9);
        rd = 5'($urandom_range(0, 6));
        ra = 5'($urandom_range(0, 7));
        rb = 5'($urandom_range(0, 7));
        off = $urandom_range(0, 63) * 4 + $urandom_range(0, 3);
        if ($urandom_range(0, 1) == 0) begin
            ra = 5'd7; imm = 12'(off);
        end else begin
            imm = 12'(off + 256);
            if (k >= 6 && k <= 8) ra = 5'd0;
        end
        if (k <= 2) return enc_add(rb, 5'($urandom_range(0, 7)), rd);
        if (k <= 5) return enc_i(12'($urandom), 5'($urandom_range(0, 7)), 3'b000, rd, B_IMM);
        if (k <= 7) return enc_i(imm, ra, 3'b010, rd, B_LD);
        if (k == 8) return enc_sw(imm, rb, ra);
        return {$urandom_range(0, 32'h1FF_FFFF), 7'b1111111};
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) m_reg[i] = 'x;

        // directed program: known encodings, corner cases
        for (int i = 0; i < 128; i++) m_mem[i] = (i >= 64) ? $urandom : 32'd0;
        m_mem[0]  = 32'h00200093;                      // addi x1,x0,2
        m_mem[1]  = 32'h00200113;                      // addi x2,x0,2
        m_mem[2]  = 32'h002081b3;                      // add x3,x1,x2
        m_mem[3]  = 32'hFFFFFFFF;                      // R8
        m_mem[4]  = 32'h40208133;                      // funct7 set: R8
        m_mem[5]  = enc_i(12'd5, 5'd0, 3'b000, 5'd0, B_IMM);   // R7 write to x0
        m_mem[6]  = enc_add(5'd0, 5'd0, 5'd4);                 // R7 x0 reads zero
        m_mem[7]  = enc_i(12'hFFF, 5'd0, 3'b000, 5'd5, B_IMM); // negative imm
        m_mem[8]  = enc_i(12'h104, 5'd0, 3'b000, 5'd7, B_IMM);
        m_mem[9]  = enc_sw(12'hFFC, 5'd3, 5'd7);               // R6 store to 0x100
        m_mem[10] = enc_i(12'h101, 5'd0, 3'b010, 5'd6, B_LD);  // R5 misaligned
        m_mem[11] = enc_i(12'hFFC, 5'd7, 3'b010, 5'd1, B_LD);  // R5 negative offset
        m_mem[12] = enc_i(12'h100, 5'd0, 3'b010, 5'd2, B_LD);  // sees loading-port word
        m_mem[13] = enc_i(12'h000, 5'd0, 3'b000, 5'd3, B_LD);  // funct3 000: R8
        load_image();
        for (int i = 0; i < 12; i++) step();

        // R10: loading port mid-run stalls and writes
        ld_en = 1'b1; ld_idx = 7'd64; ld_word = 32'hCAFE0001;
        #1 chk("R10", "valid during load", {31'd0, cm_valid}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        ld_en = 1'b0;
        m_mem[64] = 32'hCAFE0001;
        #1 chk("R10", "pc held", cm_pc, m_pc);
        step();
        step();

        // random programs
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 128; i++) m_mem[i] = (i >= 64) ? $urandom : 32'd0;
            for (int i = 1; i < 7; i++)
                m_mem[i-1] = enc_i(12'($urandom), 5'd0, 3'b000, 5'(i), B_IMM);
            m_mem[6] = enc_i(12'h100, 5'd0, 3'b000, 5'd7, B_IMM);
            for (int i = 7; i < 64; i++) m_mem[i] = rand_inst();
            load_image();
            for (int i = 0; i < 64; i++) step();
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule